// File: doc/BRIEF.md
# SPI Interrupt Status and Clear Logic

This block is the interrupt section of a SPI master controller. It keeps a raw status bit for each of three events that the transfer sequencer reports with single-cycle pulses: a transfer finished, received data is ready, and a received word was lost to overflow. Each raw bit stays set until software clears it through a write-one-to-clear register. Three enable bits live in the controller's control register, at positions that differ from the status bits they gate. The block remaps them to the status layout, forms a masked status, and drives one level-sensitive interrupt line.

Software reaches the block through register read and write strobes with a word index. The block decodes only the indices it owns: control (0), clear (3), masked status (8) and raw status (9). It ignores writes to the read-only indices. A read returns its word one cycle after the strobe and holds that word until the next read. Setting the top bit of a control write is a soft reset, and it returns all interrupt state to zero.

Top module: `spi_irq_ctrl`

## Requirements
- R1: A pulse on `evt_i` sets the matching raw bit in the cycle after the edge that samples it. Bit 0 is transfer done, bit 1 is receive ready and bit 2 is receive overflow. The raw word is read at index 9.
- R2: A write to index 0 loads the enables from the data bits: bit 5 enables transfer done, bit 4 enables receive ready and bit 6 enables overflow. A read of index 0 returns the enables at those positions, and every other bit reads as zero.
- R3: A read of index 8 returns the raw status ANDed with the remapped enables, in the raw bit layout.
- R4: `irq_o` is high exactly when at least one masked bit is set. It follows a raw or enable change in the same cycle that the change becomes visible.
- R5: A write to index 3 clears each raw bit whose data bit (0, 1 or 2) is 1. It leaves bits written as 0 unchanged.
- R6: When an event and a clear of the same raw bit arrive in the same cycle, the bit ends up set.
- R7: Writes to index 2, 8 or 9 change neither the raw status nor the enables.
- R8: A write to index 0 with bit 31 set clears all raw bits and all enables, whatever the other data bits hold.
- R9: After reset, the raw status, the enables, `rd_data_o` and `irq_o` are all zero.
- R10: `rd_data_o` takes the addressed word at the edge that samples `rd_en_i`, and holds it while `rd_en_i` is low. A read of any index other than 0, 8 or 9 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 3 | Event pulses from the sequencer (bit 0 done, bit 1 receive ready, bit 2 overflow) |
| wr_en_i | input | 1 | Register write strobe |
| wr_idx_i | input | 4 | Word index of the write |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_idx_i | input | 4 | Word index of the read |
| rd_data_o | output | 32 | Registered read data |
| irq_o | output | 1 | Level interrupt |

## Verification
Raw bits, enables and the read word each pass through exactly one register. Their effect is therefore due right after the clock edge that samples the event, write or read strobe. The interrupt is combinational from those registers and changes in that same cycle. The bench drives every strobe on the falling edge and samples one time unit after the next rising edge, so each check lands in the first cycle where the result is defined. The checks for ignored writes and for read-hold read the state back through index 9 and index 0, or watch `irq_o`, before any further stimulus arrives.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
    localparam int REG_W = 32;
    localparam int IDX_W = 4;
    localparam int NEVT  = 3;

    localparam logic [IDX_W-1:0] IDX_CTRL = 4'd0;
    localparam logic [IDX_W-1:0] IDX_STAT = 4'd2;
    localparam logic [IDX_W-1:0] IDX_CLR  = 4'd3;
    localparam logic [IDX_W-1:0] IDX_MASK = 4'd8;
    localparam logic [IDX_W-1:0] IDX_RAW  = 4'd9;

    // control-word position of the enable for event k (done, rxrdy, overflow)
    localparam int CTL_POS [NEVT] = '{5, 4, 6};
    localparam int CTL_SRST = 31;

    typedef logic [NEVT-1:0]  evt_vec_t;
    typedef logic [REG_W-1:0] word_t;

    typedef struct packed {
        evt_vec_t en;
        word_t    rd;
    } top_state_t;
endpackage

// File: rtl/spi_irq_enmap.sv
module spi_irq_enmap
    import spi_irq_pkg::*;
(
    input  word_t    ctrl_word_i,
    input  evt_vec_t en_i,
    output evt_vec_t en_o,
    output word_t    ctrl_view_o
);
    // gather enables from control layout and scatter them back for readback
    always_comb begin
        ctrl_view_o = '0;
        for (int k = 0; k < NEVT; k++) begin
            ctrl_view_o[CTL_POS[k]] = en_i[k];
        end
    end

    for (genvar k = 0; k < NEVT; k++) begin : g_gather
        assign en_o[k] = ctrl_word_i[CTL_POS[k]];
    end
endmodule

// File: rtl/spi_irq_raw.sv
module spi_irq_raw
    import spi_irq_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     srst_i,
    input  evt_vec_t set_i,
    input  evt_vec_t clr_i,
    output evt_vec_t raw_o
);
    evt_vec_t raw_d, raw_q;

    always_comb begin
        if (srst_i) begin
            raw_d = '0;
        end else begin
            raw_d = (raw_q & ~clr_i) | set_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) raw_q <= '0;
        else         raw_q <= raw_d;
    end

    assign raw_o = raw_q;

    AST_SET_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!srst_i && set_i != '0) |=> ((raw_q & $past(set_i)) == $past(set_i))); // R6
    AST_CLR_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((clr_i & ~set_i) != '0) |=> ((raw_q & $past(clr_i & ~set_i)) == '0)); // R5
    AST_RAW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!srst_i && set_i == '0 && clr_i == '0) |=> $stable(raw_q)); // R7
endmodule

// File: rtl/spi_irq_rdmux.sv
module spi_irq_rdmux
    import spi_irq_pkg::*;
(
    input  logic [IDX_W-1:0] idx_i,
    input  word_t            ctrl_view_i,
    input  evt_vec_t         raw_i,
    input  evt_vec_t         masked_i,
    output word_t            word_o
);
    always_comb begin
        word_o = '0;
        unique case (idx_i)
            IDX_CTRL: word_o = ctrl_view_i;
            IDX_MASK: word_o[NEVT-1:0] = masked_i;
            IDX_RAW:  word_o[NEVT-1:0] = raw_i;
            default:  word_o = '0;
        endcase
    end
endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
    import spi_irq_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [NEVT-1:0]  evt_i,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic             rd_en_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic [REG_W-1:0] rd_data_o,
    output logic             irq_o
);
    top_state_t st_d, st_q;
    evt_vec_t   en_from_wr, raw, masked, clr_vec;
    word_t      ctrl_view, rd_word;
    logic       ctrl_wr, srst;

    assign ctrl_wr = wr_en_i && (wr_idx_i == IDX_CTRL);
    assign srst    = ctrl_wr && wr_data_i[CTL_SRST];
    assign clr_vec = (wr_en_i && wr_idx_i == IDX_CLR) ? wr_data_i[NEVT-1:0] : '0;

    spi_irq_enmap u_enmap (
        .ctrl_word_i (wr_data_i),
        .en_i        (st_q.en),
        .en_o        (en_from_wr),
        .ctrl_view_o (ctrl_view)
    );

    spi_irq_raw u_raw (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .srst_i (srst),
        .set_i  (evt_i),
        .clr_i  (clr_vec),
        .raw_o  (raw)
    );

    assign masked = raw & st_q.en;

    spi_irq_rdmux u_rdmux (
        .idx_i       (rd_idx_i),
        .ctrl_view_i (ctrl_view),
        .raw_i       (raw),
        .masked_i    (masked),
        .word_o      (rd_word)
    );

    always_comb begin
        st_d = st_q;
        if (srst) begin
            st_d.en = '0;
        end else if (ctrl_wr) begin
            st_d.en = en_from_wr;
        end
        if (rd_en_i) begin
            st_d.rd = rd_word;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rd_data_o = st_q.rd;
    assign irq_o     = |masked;

    AST_SRST_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        srst |=> (raw == '0 && st_q.en == '0 && !irq_o)); // R8
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (st_q.en != '0 && raw != '0)); // R4
    AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> $stable(rd_data_o)); // R10
    AST_RO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && (wr_idx_i == IDX_STAT || wr_idx_i == IDX_MASK || wr_idx_i == IDX_RAW)
         && evt_i == '0) |=> ($stable(st_q.en) && $stable(raw))); // R7
endmodule

// File: tb/spi_irq_ctrl_tb.sv
module spi_irq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  evt = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic        irq;
    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    spi_irq_ctrl u_dut (
        .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
        .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_idx_i(rd_idx),
        .rd_data_o(rd_data), .irq_o(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // stimulus changes on the falling edge; results sampled 1 after the rising edge
    task automatic step(logic [2:0] e, logic we, logic [3:0] wi, logic [31:0] wd);
        @(negedge clk);
        evt = e; wr_en = we; wr_idx = wi; wr_data = wd;
        @(posedge clk); #1;
        @(negedge clk);
        evt = '0; wr_en = 1'b0;
    endtask

    task automatic rd(logic [3:0] idx, output logic [31:0] val);
        @(negedge clk);
        rd_en = 1'b1; rd_idx = idx;
        @(posedge clk); #1;
        val = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R9 rd_data", rd_data, 32'h0);
        check("R9 irq", {31'h0, irq}, 32'h0);
        rd(4'd9, v); check("R9 raw", v, 32'h0);
        rd(4'd0, v); check("R9 ctrl", v, 32'h0);
    endtask

    task automatic t_events();
        logic [31:0] v;
        step(3'b001, 1'b0, 4'd0, 0); rd(4'd9, v); check("R1 done", v, 32'h1);
        step(3'b010, 1'b0, 4'd0, 0); rd(4'd9, v); check("R1 rxrdy", v, 32'h3);
        step(3'b100, 1'b0, 4'd0, 0); rd(4'd9, v); check("R1 ovf", v, 32'h7);
        check("R4 irq no enables", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_enables();
        logic [31:0] v;
        step(3'b000, 1'b1, 4'd0, 32'h0000_FF20); // only bit 5 of enables
        check("R4 irq same cycle", {31'h0, irq}, 32'h1);
        rd(4'd0, v); check("R2 ctrl readback", v, 32'h20);
        rd(4'd8, v); check("R3 masked done", v, 32'h1);
        step(3'b000, 1'b1, 4'd0, 32'h50);
        rd(4'd0, v); check("R2 ctrl 4,6", v, 32'h50);
        rd(4'd8, v); check("R3 masked rx+ovf", v, 32'h6);
    endtask

    task automatic t_clear();
        logic [31:0] v;
        step(3'b000, 1'b1, 4'd3, 32'h2);
        rd(4'd9, v); check("R5 clear bit1", v, 32'h5);
        check("R4 irq ovf only", {31'h0, irq}, 32'h1);
        step(3'b000, 1'b1, 4'd3, 32'h4);
        check("R4 irq drops", {31'h0, irq}, 32'h0);
        rd(4'd9, v); check("R5 clear bit2", v, 32'h1);
        step(3'b001, 1'b1, 4'd3, 32'h1);
        rd(4'd9, v); check("R6 set wins", v, 32'h1);
    endtask

    task automatic t_readonly();
        logic [31:0] v;
        step(3'b000, 1'b1, 4'd2, 32'h0);
        step(3'b000, 1'b1, 4'd8, 32'h0);
        step(3'b000, 1'b1, 4'd9, 32'h0);
        rd(4'd9, v); check("R7 raw kept", v, 32'h1);
        rd(4'd0, v); check("R7 enables kept", v, 32'h50);
    endtask

    task automatic t_readmux();
        logic [31:0] v;
        rd(4'd5, v); check("R10 other idx", v, 32'h0);
        rd(4'd9, v);
        @(negedge clk); rd_idx = 4'd0;
        @(posedge clk); #1;
        check("R10 hold", rd_data, 32'h1);
    endtask

    task automatic t_softreset();
        logic [31:0] v;
        step(3'b000, 1'b1, 4'd0, 32'h70);
        step(3'b111, 1'b0, 4'd0, 0);
        check("R4 irq before srst", {31'h0, irq}, 32'h1);
        step(3'b000, 1'b1, 4'd0, 32'h8000_0070);
        check("R8 irq", {31'h0, irq}, 32'h0);
        rd(4'd9, v); check("R8 raw", v, 32'h0);
        rd(4'd0, v); check("R8 enables", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_events();
        t_enables();
        t_clear();
        t_readonly();
        t_readmux();
        t_softreset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule